// File: doc/BRIEF.md
# Receive Overrun Statistics Classifier

This block sits beside an Ethernet MAC receive path. It keeps three saturating statistics counters for received frames that were dropped because receive resources ran out. Each frame is tracked from its start strobe to its end strobe. Resources are missing when the cell FIFO is full or when no DMA buffer is available, which means the head descriptor pointer is zero. The block records when the loss happened: at the start of the frame or after the frame had started. It also records whether the DMA buffer was the cause. Frame error flags for CRC, alignment and code errors are accepted on input and have no effect on any count.

When the end strobe arrives, the frame is classified once and at most one increment reaches each counter. A frame that lost a DMA buffer bumps the DMA counter and also its start-of-frame or mid-frame counter in that same cycle. Software reads the counters through a small register port with one cycle of read latency. Writing a value to a counter subtracts that value from it, so writing back the value just read clears the counter without losing an increment that lands in the same cycle.

Top module: `rx_ovr_stats`

## Requirements
- R1: A frame is counted only if `addr_hit` is high in its `frm_end` cycle. Frame length does not matter: a frame whose start and end fall in one cycle is classified, and so is a frame of any number of cycles.
- R2: If `fifo_full` is high or `dma_ready` is low in the `frm_start` cycle, the start-of-frame counter (register address 0) rises by one at the end of that frame.
- R3: If the frame started without loss and `fifo_full` is high or `dma_ready` is low on any later cycle up to and including its `frm_end` cycle, the mid-frame counter (address 1) rises by exactly one, however many such cycles occur.
- R4: A frame that had a start-of-frame overrun never also increments the mid-frame counter.
- R5: The DMA counter (address 2) rises by one for a counted frame that saw `dma_ready` low at start or mid-frame. A loss caused only by `fifo_full` leaves it unchanged.
- R6: `crc_err`, `align_err` and `code_err` change no count.
- R7: A DMA-caused overrun increments the DMA counter and its start or mid-frame counter on the same clock edge.
- R8: Each counter stops at all-ones instead of wrapping.
- R9: A write (`reg_en`=1, `reg_wr`=1) subtracts `reg_wdata` from the addressed counter and clamps the result at zero. A frame-end increment in the same cycle is still added after the subtraction.
- R10: A read (`reg_en`=1, `reg_wr`=0) presents the addressed counter's value on `reg_rdata` one cycle later. Address 3 reads as zero.
- R11: A synchronous active-high `rst` clears all counters and the frame state.
- R12: A `frm_start` during an active frame abandons the old frame, and losses from the old frame are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | First cycle of a received frame |
| frm_end | input | 1 | Last cycle of a received frame |
| addr_hit | input | 1 | Frame matched unicast/broadcast/multicast or promiscuous acceptance |
| fifo_full | input | 1 | Receive cell FIFO has no room |
| dma_ready | input | 1 | Head descriptor pointer is nonzero |
| crc_err | input | 1 | Frame CRC error (ignored) |
| align_err | input | 1 | Frame alignment error (ignored) |
| code_err | input | 1 | Frame code error (ignored) |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write (subtract), 0 = read |
| reg_addr | input | ADDR_W | Counter select: 0 start, 1 mid, 2 DMA |
| reg_wdata | input | CNT_W | Value to subtract |
| reg_rdata | output | CNT_W | Read data, one cycle after the request |

## Verification
A table of frames drives every combination of loss time and cause: a clean frame, FIFO-only and DMA-only losses at start, single and repeated mid-frame losses, a start loss followed by mid-frame losses, mixed FIFO-then-DMA mid-frame loss, and unmatched frames with losses. Each row separates start from mid-frame classification and cause attribution, and the error flags vary across rows to show they do not matter. Directed cases cover single-cycle and very long frames, a restart mid-frame, a subtracting write on the same edge as an increment, underflow clamping, and saturation. Saturation runs on a second instance with 3-bit counters, and the full-width instance counts the same frames beside it.

// File: rtl/rx_ovr_pkg.sv
package rx_ovr_pkg;
    // per-frame classification result, one bit per statistic
    typedef struct packed {
        logic dma;
        logic mof;
        logic sof;
    } ovr_evt_t;

    // per-frame tracking state
    typedef struct packed {
        logic active;
        logic sof;
        logic mof;
        logic dma;
    } frm_state_t;

    localparam int NUM_STATS = 3;
endpackage

// File: rtl/rx_ovr_frame_track.sv
module rx_ovr_frame_track
    import rx_ovr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frm_start,
    input  logic     frm_end,
    input  logic     addr_hit,
    input  logic     fifo_full,
    input  logic     dma_ready,
    output ovr_evt_t evt_o
);
    frm_state_t st_d, st_q;
    frm_state_t cur;
    ovr_evt_t   evt;
    logic       short_now;

    always_comb begin
        short_now = fifo_full | ~dma_ready;
        st_d      = st_q;
        evt       = '0;
        cur       = st_q;
        if (frm_start) begin
            // fresh frame: any older frame is abandoned (R12)
            cur.active = 1'b1;
            cur.sof    = short_now;
            cur.mof    = 1'b0;
            cur.dma    = ~dma_ready;
        end else if (st_q.active && short_now && !st_q.sof) begin
            // loss after a successful start: latched once (R3)
            cur.mof = 1'b1;
            if (!dma_ready) cur.dma = 1'b1;
        end
        if (frm_end && cur.active) begin
            evt.sof = addr_hit & cur.sof;
            evt.mof = addr_hit & cur.mof & ~cur.sof;
            evt.dma = addr_hit & cur.dma;
            st_d    = '0;
        end else begin
            st_d = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign evt_o = evt;

    // R1: events only come out on a frame-end cycle
    p_evt_at_end_r1: assert property (@(posedge clk) disable iff (rst)
        (evt_o != '0) |-> frm_end);
    // R4: start and mid-frame events never coincide
    p_sof_mof_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(evt_o.sof && evt_o.mof));
    // R11: no event right after reset without a new start
    p_idle_after_reset_r11: assert property (@(posedge clk)
        (rst && !frm_start) |=> (evt_o == '0 || frm_start));
endmodule

// File: rtl/rx_ovr_sat_ctr.sv
module rx_ovr_sat_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q, after_sub;

    always_comb begin
        after_sub = cnt_q;
        if (wr_en) after_sub = (wr_val > cnt_q) ? '0 : cnt_q - wr_val;
        cnt_d = after_sub;
        if (inc && after_sub != CNT_MAX) cnt_d = after_sub + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R8: a full counter stays full until software subtracts
    p_hold_max_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !wr_en) |=> cnt_q == CNT_MAX);
    // R9: without a write the counter moves by at most one
    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
    // R11: reset clears the counter
    p_reset_zero_r11: assert property (@(posedge clk)
        rst |=> cnt_q == '0);
endmodule

// File: rtl/rx_ovr_stats.sv
module rx_ovr_stats
    import rx_ovr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              addr_hit,
    input  logic              fifo_full,
    input  logic              dma_ready,
    input  logic              crc_err,
    input  logic              align_err,
    input  logic              code_err,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata
);
    ovr_evt_t                   evt;
    logic [NUM_STATS-1:0]       inc_vec;
    logic [CNT_W-1:0]           cnt [NUM_STATS];
    logic [CNT_W-1:0]           rd_d, rd_q;
    logic                       err_any;

    // error flags are part of the frame status but classify nothing (R6)
    assign err_any = crc_err | align_err | code_err;

    rx_ovr_frame_track u_track (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .frm_end   (frm_end),
        .addr_hit  (addr_hit),
        .fifo_full (fifo_full),
        .dma_ready (dma_ready),
        .evt_o     (evt)
    );

    assign inc_vec = {evt.dma, evt.mof, evt.sof};

    for (genvar gi = 0; gi < NUM_STATS; gi++) begin : g_ctr
        logic wr_sel;
        assign wr_sel = reg_en && reg_wr && (reg_addr == ADDR_W'(gi));
        rx_ovr_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .inc    (inc_vec[gi]),
            .wr_en  (wr_sel),
            .wr_val (reg_wdata),
            .cnt_o  (cnt[gi])
        );
    end

    always_comb begin
        rd_d = rd_q;
        if (reg_en && !reg_wr) begin
            rd_d = '0;
            for (int i = 0; i < NUM_STATS; i++)
                if (reg_addr == ADDR_W'(i)) rd_d = cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign reg_rdata = rd_q;

    // R7: a DMA event always travels with a start or mid-frame event
    p_dma_paired_r7: assert property (@(posedge clk) disable iff (rst)
        evt.dma |-> (evt.sof || evt.mof));
    // R10: read data appears one cycle after the request
    p_read_lat_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_addr == '0) |=> reg_rdata == $past(cnt[0]));
    // R6: error flags never make an event appear outside a frame end
    p_err_inert_r6: assert property (@(posedge clk) disable iff (rst)
        (err_any && !frm_end) |-> inc_vec == '0);
endmodule

// File: tb/rx_ovr_stats_tb.sv
module rx_ovr_stats_tb_top;
    localparam int NW = 3;
    logic clk = 1'b0;
    logic rst;
    logic frm_start, frm_end, addr_hit, fifo_full, dma_ready;
    logic crc_err, align_err, code_err;
    logic reg_en, reg_wr;
    logic [1:0] reg_addr;
    logic [31:0] reg_wdata, rdata;
    logic [NW-1:0] rdata_n;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_s, exp_m, exp_d;

    always #2 clk = ~clk; // 250 MHz

    rx_ovr_stats dut_i (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
        .addr_hit(addr_hit), .fifo_full(fifo_full), .dma_ready(dma_ready),
        .crc_err(crc_err), .align_err(align_err), .code_err(code_err),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata));

    rx_ovr_stats #(.CNT_W(NW)) dut_n (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
        .addr_hit(addr_hit), .fifo_full(fifo_full), .dma_ready(dma_ready),
        .crc_err(crc_err), .align_err(align_err), .code_err(code_err),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata[NW-1:0]), .reg_rdata(rdata_n));

    // [14]start fifo [13]start dma missing [12:10]mid fifo [9:7]mid dma missing
    // [6]hit [5:3]errors [2]+sof [1]+mof [0]+dma
    localparam int NV = 11;
    localparam logic [14:0] VEC [NV] = '{
        15'b0_0_000_000_1_000_000,  // R1 clean frame
        15'b1_0_000_000_1_000_100,  // R2 fifo full at start
        15'b0_1_000_000_1_000_101,  // R2 R5 R7 no buffer at start
        15'b0_0_010_000_1_000_010,  // R3 single mid fifo loss
        15'b0_0_000_111_1_000_011,  // R3 R5 repeated mid dma loss
        15'b1_0_111_000_1_000_100,  // R4 start loss then mid losses
        15'b1_1_000_000_0_000_000,  // R1 no address match
        15'b1_0_000_000_1_111_100,  // R6 all error flags
        15'b0_0_001_100_1_101_011,  // R3 R5 fifo then dma at end cycle
        15'b1_1_000_000_1_010_101,  // R2 R5 both missing at start
        15'b0_0_010_010_0_000_000   // R1 mid loss, unmatched
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); reg_en = 1; reg_wr = 0; reg_addr = a;
        @(negedge clk); reg_en = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk); reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_en = 0; reg_wr = 0;
    endtask

    task automatic check_all(string req);
        rd(0); check({req, " sof"}, rdata, exp_s);
        rd(1); check({req, " mof"}, rdata, exp_m);
        rd(2); check({req, " dma"}, rdata, exp_d);
    endtask

    task automatic idle();
        frm_start = 0; frm_end = 0; fifo_full = 0; dma_ready = 1;
        crc_err = 0; align_err = 0; code_err = 0;
    endtask

    task automatic one_cycle_frame(input logic ff);
        @(negedge clk); frm_start = 1; frm_end = 1; addr_hit = 1; fifo_full = ff;
        @(negedge clk); idle();
    endtask

    initial begin
        idle(); addr_hit = 0; reg_en = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        exp_s = 0; exp_m = 0; exp_d = 0;
        check_all("R11 reset");

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            frm_start = 1; fifo_full = VEC[v][14]; dma_ready = !VEC[v][13];
            addr_hit = VEC[v][6];
            {crc_err, align_err, code_err} = VEC[v][5:3];
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                frm_start = 0; fifo_full = VEC[v][10+c]; dma_ready = !VEC[v][7+c];
                frm_end = (c == 2);
            end
            @(negedge clk); idle();
            exp_s += 32'(VEC[v][2]); exp_m += 32'(VEC[v][1]); exp_d += 32'(VEC[v][0]);
            check_all($sformatf("R2 R3 R4 R5 R6 vec%0d", v));
        end

        rd(3); check("R10 unused address", rdata, 0);

        wr(0, exp_s); exp_s = 0;
        rd(0); check("R9 subtract clears", rdata, exp_s);

        // R9 write on the same edge as a mid-frame increment
        @(negedge clk); frm_start = 1; addr_hit = 1;
        @(negedge clk); frm_start = 0; fifo_full = 1;
        @(negedge clk); fifo_full = 0; frm_end = 1;
        reg_en = 1; reg_wr = 1; reg_addr = 1; reg_wdata = exp_m;
        @(negedge clk); idle(); reg_en = 0; reg_wr = 0;
        exp_m = 1;
        check_all("R9 concurrent write and increment");

        wr(2, 100); exp_d = 0;
        rd(2); check("R9 underflow clamp", rdata, 0);

        one_cycle_frame(1); exp_s++;
        check_all("R1 R2 single-cycle frame");

        // R12 restart drops a pending mid-frame loss
        @(negedge clk); frm_start = 1; addr_hit = 1;
        @(negedge clk); frm_start = 0; fifo_full = 1;
        @(negedge clk); fifo_full = 0; frm_start = 1;
        @(negedge clk); frm_start = 0;
        @(negedge clk); frm_end = 1;
        @(negedge clk); idle();
        check_all("R12 restart");

        // R1 long frame, loss late in the frame
        @(negedge clk); frm_start = 1; addr_hit = 1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk); frm_start = 0; fifo_full = (c == 30); dma_ready = (c != 31);
            frm_end = (c == 39);
        end
        @(negedge clk); idle();
        exp_m++; exp_d++;
        check_all("R1 R3 R7 long frame");

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        exp_s = 0; exp_m = 0; exp_d = 0;
        check_all("R11 reset after traffic");

        // R8 saturation on the narrow instance
        for (int k = 0; k < 9; k++) one_cycle_frame(1);
        rd(0);
        check("R8 wide keeps counting", rdata, 9);
        check("R8 narrow saturates", 32'(rdata_n), 7);
        one_cycle_frame(1);
        rd(0);
        check("R8 narrow stays at max", 32'(rdata_n), 7);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule